// File: doc/BRIEF.md
# Tamper Deglitch and Zeroize Controller

This block guards secret state against an external tamper sensor. An active-high destruct request arrives asynchronously, is brought into the clock domain by a two-stage synchronizer and is then filtered by a run-length counter. Only a request that stays high for an unbroken run of clock samples is accepted. The length of that run is derived from the clock period parameter, so short spikes are discarded and sustained requests are honoured.

An accepted request starts a destruction sequence. The 64-bit key register is zeroed on the trigger edge. The vector RAM is then wiped one word per cycle. After the wipe, a power-cut output is driven for a fixed number of cycles so that the external memory supply drops. When the cut ends, a sticky flag records that the part has been tampered with. The key and the vector RAM can be written through a plain write port. That port is locked while the sequence runs.

Top module: `tamper_zeroize`

## Requirements
- R1: After reset the key reads zero, every vector RAM word reads zero, and both `pwr_cut_o` and `tampered_o` are 0.
- R2: A high level on `tamper_i` that covers fewer than ACCEPT_CYC consecutive rising clock edges has no effect. ACCEPT_CYC is ceil(ACCEPT_NS / CLK_PERIOD_NS), which is 125 at the defaults (2.5 µs at 20 ns). In particular a 2 µs pulse is rejected: the key and the RAM keep their contents and no power cut occurs.
- R3: A high level on `tamper_i` that covers at least ACCEPT_CYC consecutive rising edges is accepted. In particular a 3 µs pulse is always accepted.
- R4: A single clock sample of `tamper_i` low restarts the run count, so two sub-threshold pulses separated by one low sample are both rejected.
- R5: The key reads all zeros after rising edge ACCEPT_CYC+2, counted from the first edge that samples `tamper_i` high. It still holds its old value after edge ACCEPT_CYC+1.
- R6: The vector RAM is cleared one word per cycle in ascending address order. Word i reads zero after edge ACCEPT_CYC+3+i. The last word keeps its value up to that point.
- R7: `pwr_cut_o` rises right after the last word is cleared and stays high for exactly CUT_CYCLES cycles.
- R8: `tampered_o` rises on the edge that ends the power cut. It then stays 1 until reset.
- R9: Writes to the key (`key_wr_i`) and to the RAM (`vec_we_i`) are ignored while the wipe or the cut is in progress. They take effect on the next edge at any other time, including after the sequence is done.
- R10: A new accepted request after the sequence has finished runs the whole destruction sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tamper_i | input | 1 | Asynchronous active-high destruct request |
| key_wr_i | input | 1 | Key write strobe |
| key_wdata_i | input | KEY_W | Key value to load |
| key_o | output | KEY_W | Current key contents |
| vec_we_i | input | 1 | Vector RAM write strobe |
| vec_addr_i | input | $clog2(VEC_WORDS) | Vector RAM address for read and write |
| vec_wdata_i | input | WORD_W | Vector RAM write data |
| vec_rdata_o | output | WORD_W | Vector RAM word at `vec_addr_i` (combinational read) |
| pwr_cut_o | output | 1 | Memory supply cut, high while cutting |
| tampered_o | output | 1 | Sticky flag: a destruction sequence has completed |

## Verification
All timing is counted in rising edges from the first edge that samples `tamper_i` high. Two synchronizer edges and ACCEPT_CYC counter edges place the key clear on edge ACCEPT_CYC+2. The word wipes follow on the next VEC_WORDS edges. The cut spans the CUT_CYCLES edges after that, and the flag rises on the edge that ends the cut. The bench raises and lowers the input on falling edges, counts every rising edge itself, and samples each output at the falling edge just before and just after the edge on which it is due to change. Reject cases are judged only after a settling window longer than the whole sequence.

// File: rtl/tz_pkg.sv
package tz_pkg;

    typedef enum logic [1:0] {
        TZ_IDLE = 2'd0,
        TZ_WIPE = 2'd1,
        TZ_CUT  = 2'd2,
        TZ_DONE = 2'd3
    } tz_state_e;

endpackage

// File: rtl/tz_sync.sv
module tz_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];

endmodule

// File: rtl/tz_deglitch.sv
module tz_deglitch #(
    parameter int ACCEPT_CYC = 125
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic fire_o
);

    localparam int CW = $clog2(ACCEPT_CYC + 1);
    localparam logic [CW-1:0] SAT  = CW'(ACCEPT_CYC);
    localparam logic [CW-1:0] LAST = CW'(ACCEPT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Run-length count of consecutive high samples; saturates so one run fires once.
    always_comb begin
        cnt_d = cnt_q;
        if (!level_i)          cnt_d = '0;
        else if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign fire_o = level_i && (cnt_q == LAST);

endmodule

// File: rtl/tz_seq.sv
module tz_seq
    import tz_pkg::*;
#(
    parameter int WORDS      = 16,
    parameter int CUT_CYCLES = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     trig_i,
    output logic                     wipe_en_o,
    output logic [$clog2(WORDS)-1:0] wipe_idx_o,
    output logic                     busy_o,
    output logic                     cut_o,
    output logic                     tampered_o
);

    localparam int AW = $clog2(WORDS);
    localparam int CCW = $clog2(CUT_CYCLES + 1);

    typedef struct packed {
        tz_state_e      st;
        logic [AW-1:0]  idx;
        logic [CCW-1:0] cut;
        logic           flag;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            TZ_IDLE, TZ_DONE: begin
                if (trig_i) begin
                    s_d.st  = TZ_WIPE;
                    s_d.idx = '0;
                end
            end
            TZ_WIPE: begin
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == AW'(WORDS - 1)) begin
                    s_d.st  = TZ_CUT;
                    s_d.cut = '0;
                end
            end
            TZ_CUT: begin
                s_d.cut = s_q.cut + 1'b1;
                if (s_q.cut == CCW'(CUT_CYCLES - 1)) begin
                    s_d.st   = TZ_DONE;
                    s_d.flag = 1'b1;
                end
            end
            default: s_d.st = TZ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '{st: TZ_IDLE, idx: '0, cut: '0, flag: 1'b0};
        else         s_q <= s_d;
    end

    assign wipe_en_o  = (s_q.st == TZ_WIPE);
    assign wipe_idx_o = s_q.idx;
    assign cut_o      = (s_q.st == TZ_CUT);
    assign busy_o     = (s_q.st == TZ_WIPE) || (s_q.st == TZ_CUT);
    assign tampered_o = s_q.flag;

endmodule

// File: rtl/tz_store.sv
module tz_store #(
    parameter int KEY_W  = 64,
    parameter int WORDS  = 16,
    parameter int WORD_W = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     clear_key_i,
    input  logic                     wipe_en_i,
    input  logic [$clog2(WORDS)-1:0] wipe_idx_i,
    input  logic                     lock_i,
    input  logic                     key_wr_i,
    input  logic [KEY_W-1:0]         key_wdata_i,
    input  logic                     vec_we_i,
    input  logic [$clog2(WORDS)-1:0] vec_addr_i,
    input  logic [WORD_W-1:0]        vec_wdata_i,
    output logic [KEY_W-1:0]         key_o,
    output logic [WORD_W-1:0]        vec_rdata_o
);

    typedef struct packed {
        logic [KEY_W-1:0]             key;
        logic [WORDS-1:0][WORD_W-1:0] mem;
    } store_t;

    store_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear_key_i)              r_d.key = '0;
        else if (key_wr_i && !lock_i) r_d.key = key_wdata_i;

        if (wipe_en_i)                r_d.mem[wipe_idx_i] = '0;
        else if (vec_we_i && !lock_i) r_d.mem[vec_addr_i] = vec_wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign key_o       = r_q.key;
    assign vec_rdata_o = r_q.mem[vec_addr_i];

endmodule

// File: rtl/tamper_zeroize.sv
module tamper_zeroize #(
    parameter int CLK_PERIOD_NS = 20,
    parameter int ACCEPT_NS     = 2500,
    parameter int KEY_W         = 64,
    parameter int VEC_WORDS     = 16,
    parameter int WORD_W        = 8,
    parameter int CUT_CYCLES    = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         tamper_i,
    input  logic                         key_wr_i,
    input  logic [KEY_W-1:0]             key_wdata_i,
    output logic [KEY_W-1:0]             key_o,
    input  logic                         vec_we_i,
    input  logic [$clog2(VEC_WORDS)-1:0] vec_addr_i,
    input  logic [WORD_W-1:0]            vec_wdata_i,
    output logic [WORD_W-1:0]            vec_rdata_o,
    output logic                         pwr_cut_o,
    output logic                         tampered_o
);

    localparam int ACCEPT_RAW = (ACCEPT_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int ACCEPT_CYC = (ACCEPT_RAW < 1) ? 1 : ACCEPT_RAW;
    localparam int AW         = $clog2(VEC_WORDS);

    logic          tamper_sync;
    logic          fire;
    logic          wipe_en;
    logic [AW-1:0] wipe_idx;
    logic          busy;

    tz_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (tamper_i),
        .sync_o  (tamper_sync)
    );

    tz_deglitch #(.ACCEPT_CYC(ACCEPT_CYC)) i_deglitch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (tamper_sync),
        .fire_o  (fire)
    );

    tz_seq #(.WORDS(VEC_WORDS), .CUT_CYCLES(CUT_CYCLES)) i_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .trig_i     (fire),
        .wipe_en_o  (wipe_en),
        .wipe_idx_o (wipe_idx),
        .busy_o     (busy),
        .cut_o      (pwr_cut_o),
        .tampered_o (tampered_o)
    );

    tz_store #(.KEY_W(KEY_W), .WORDS(VEC_WORDS), .WORD_W(WORD_W)) i_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_key_i (fire),
        .wipe_en_i   (wipe_en),
        .wipe_idx_i  (wipe_idx),
        .lock_i      (busy),
        .key_wr_i    (key_wr_i),
        .key_wdata_i (key_wdata_i),
        .vec_we_i    (vec_we_i),
        .vec_addr_i  (vec_addr_i),
        .vec_wdata_i (vec_wdata_i),
        .key_o       (key_o),
        .vec_rdata_o (vec_rdata_o)
    );

endmodule

// File: rtl/tz_checker.sv
module tz_checker #(
    parameter int KEY_W      = 64,
    parameter int CUT_CYCLES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fire_i,
    input logic             busy_i,
    input logic [KEY_W-1:0] key_i,
    input logic             cut_i,
    input logic             tampered_i
);

    localparam int RW = $clog2(CUT_CYCLES + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)    run_q <= '0;
        else if (cut_i) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    // R5: the key is zero on the cycle after an accepted trigger
    p_key_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> (key_i == '0));

    // R9: no key load can slip in while the sequence runs
    p_key_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !fire_i) |=> (key_i == '0));

    // R7: the cut never exceeds its length
    p_cut_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cut_i |-> (run_q < RW'(CUT_CYCLES)));

    // R7: every cut lasts its full length
    p_cut_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cut_i) |-> (run_q == RW'(CUT_CYCLES)));

    // R8: the flag is sticky
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tampered_i |=> tampered_i);

    // R8: the flag first rises right after a cut
    p_flag_after_cut_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tampered_i) |-> $past(cut_i));

endmodule

bind tamper_zeroize tz_checker #(.KEY_W(KEY_W), .CUT_CYCLES(CUT_CYCLES)) i_tz_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .busy_i     (busy),
    .key_i      (key_o),
    .cut_i      (pwr_cut_o),
    .tampered_i (tampered_o)
);

// File: tb/test_tamper_zeroize.sv
module test_tamper_zeroize;

    localparam int ACC  = 125;
    localparam int VEC  = 16;
    localparam int CUT  = 8;
    localparam int T    = ACC + 2;
    localparam int SEQ  = T + VEC + CUT;
    localparam logic [63:0] KEYV = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tamper = 1'b0;
    logic        key_wr = 1'b0;
    logic [63:0] key_wdata = '0;
    logic [63:0] key;
    logic        vec_we = 1'b0;
    logic [3:0]  vec_addr = '0;
    logic [7:0]  vec_wdata = '0;
    logic [7:0]  vec_rdata;
    logic        pwr_cut;
    logic        tampered;

    int total = 0;
    int bad = 0;
    int cut_cnt = 0;

    always #10 clk = ~clk;

    tamper_zeroize i_tamper_zeroize (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tamper_i    (tamper),
        .key_wr_i    (key_wr),
        .key_wdata_i (key_wdata),
        .key_o       (key),
        .vec_we_i    (vec_we),
        .vec_addr_i  (vec_addr),
        .vec_wdata_i (vec_wdata),
        .vec_rdata_o (vec_rdata),
        .pwr_cut_o   (pwr_cut),
        .tampered_o  (tampered)
    );

    always @(negedge clk) if (pwr_cut) cut_cnt = cut_cnt + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_word(input int a, output logic [7:0] v);
        vec_addr = 4'(a);
        #1 v = vec_rdata;
    endtask

    task automatic fill();
        @(negedge clk);
        key_wr = 1'b1; key_wdata = KEYV;
        @(negedge clk);
        key_wr = 1'b0;
        for (int i = 0; i < VEC; i++) begin
            vec_we = 1'b1; vec_addr = 4'(i); vec_wdata = 8'(8'h40 + i);
            @(negedge clk);
        end
        vec_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        tamper = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tamper = 1'b0;
    endtask

    task automatic check_intact(input string req);
        logic [7:0] w;
        check(key == KEYV, req, key, KEYV);
        read_word(VEC - 1, w);
        check(w == 8'(8'h40 + VEC - 1), req, 64'(w), 64'(8'h40 + VEC - 1));
        check(cut_cnt == 0, req, 64'(cut_cnt), 64'd0);
    endtask

    task automatic test_reset();
        logic [7:0] w;
        check(key == '0, "R1 key", key, 64'd0);
        check(!pwr_cut && !tampered, "R1 flags", {62'd0, pwr_cut, tampered}, 64'd0);
        read_word(0, w);
        check(w == 8'd0, "R1 ram", 64'(w), 64'd0);
    endtask

    task automatic test_reject();
        fill();
        cut_cnt = 0;
        pulse(100);          // 2 us
        repeat (SEQ + 10) @(negedge clk);
        check_intact("R2 2us pulse");
        pulse(ACC - 1);
        repeat (SEQ + 10) @(negedge clk);
        check_intact("R2 one short of threshold");
    endtask

    task automatic test_restart();
        cut_cnt = 0;
        pulse(100);
        pulse(100);          // one low sample between runs
        repeat (SEQ + 10) @(negedge clk);
        check_intact("R4 restart");
    endtask

    task automatic test_accept();
        logic [7:0] w;
        fill();
        cut_cnt = 0;
        vec_addr = 4'(VEC - 1);
        @(negedge clk);
        tamper = 1'b1;
        for (int k = 1; k <= SEQ + 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            if (k == 150) tamper = 1'b0;   // 3 us
            if (k == T - 1) check(key == KEYV, "R5 key before", key, KEYV);
            if (k == T)     check(key == '0, "R3 R5 key cleared", key, 64'd0);
            if (k == T + 2) begin key_wr = 1'b1; key_wdata = 64'hFFFF_0000_FFFF_0000; end
            if (k == T + 3) key_wr = 1'b0;
            if (k == T + VEC - 1) begin
                check(vec_rdata == 8'(8'h40 + VEC - 1), "R6 last word held", 64'(vec_rdata), 64'(8'h40 + VEC - 1));
                check(!pwr_cut, "R7 cut not yet", 64'(pwr_cut), 64'd0);
            end
            if (k == T + VEC) begin
                check(vec_rdata == 8'd0, "R6 last word cleared", 64'(vec_rdata), 64'd0);
                check(pwr_cut, "R7 cut rises", 64'(pwr_cut), 64'd1);
            end
            if (k == T + VEC + 1) begin vec_we = 1'b1; vec_wdata = 8'h77; end
            if (k == T + VEC + 2) vec_we = 1'b0;
            if (k == SEQ - 1) begin
                check(pwr_cut, "R7 cut last cycle", 64'(pwr_cut), 64'd1);
                check(!tampered, "R8 flag not yet", 64'(tampered), 64'd0);
            end
            if (k == SEQ) begin
                check(!pwr_cut, "R7 cut released", 64'(pwr_cut), 64'd0);
                check(tampered, "R8 flag set", 64'(tampered), 64'd1);
            end
        end
        check(cut_cnt == CUT, "R7 cut length", 64'(cut_cnt), 64'(CUT));
        check(key == '0, "R9 key write blocked", key, 64'd0);
        read_word(VEC - 1, w);
        check(w == 8'd0, "R9 ram write blocked", 64'(w), 64'd0);
        for (int i = 0; i < VEC; i++) begin
            read_word(i, w);
            check(w == 8'd0, "R6 ram wiped", 64'(w), 64'd0);
        end
    endtask

    task automatic test_after_done();
        logic [7:0] w;
        @(negedge clk);
        key_wr = 1'b1; key_wdata = 64'hDEAD_BEEF_0BAD_F00D;
        vec_we = 1'b1; vec_addr = 4'd2; vec_wdata = 8'h5A;
        @(negedge clk);
        key_wr = 1'b0; vec_we = 1'b0;
        check(key == 64'hDEAD_BEEF_0BAD_F00D, "R9 key write after done", key, 64'hDEAD_BEEF_0BAD_F00D);
        read_word(2, w);
        check(w == 8'h5A, "R9 ram write after done", 64'(w), 64'h5A);
        check(tampered, "R8 flag stays", 64'(tampered), 64'd1);
    endtask

    task automatic test_repeat();
        logic [7:0] w;
        fill();
        cut_cnt = 0;
        pulse(150);
        repeat (SEQ + 10) @(negedge clk);
        check(key == '0, "R10 key cleared again", key, 64'd0);
        read_word(5, w);
        check(w == 8'd0, "R10 ram cleared again", 64'(w), 64'd0);
        check(cut_cnt == CUT, "R10 cut again", 64'(cut_cnt), 64'(CUT));
        check(tampered, "R10 R8 flag held", 64'(tampered), 64'd1);
    endtask

    task automatic test_reset_clears();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tampered, "R8 reset clears flag", 64'(tampered), 64'd0);
        check(key == '0, "R1 key after reset", key, 64'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_reject();
        test_restart();
        test_accept();
        test_after_done();
        test_repeat();
        test_reset_clears();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule